// File: doc/BRIEF.md
# Calibration Test Pulser Controller

The block produces the timing strobes for an on-board test pulser that injects charge into detector measurement chains during calibration. One free-running rate counter, clocked from the system clock, marks out the pulse period. Two pulser outputs, a low strobe and a high strobe, are each gated by their own enable and fire on the same period boundary. An 8-bit amplitude code, held in a register, is presented to an external DAC that sets the pulse height.

Commands arrive as single-cycle write strobes with a one-bit register select and a data byte. Select 0 writes the control byte: both enables and the rate choice. Select 1 writes the amplitude code. The two rates are set by parameters as fractions of the clock frequency: 8 Hz (2,000,000 cycles at 16 MHz) and 2 kHz (8,000 cycles). After reset both outputs are off, the slow rate is in force and the amplitude code is zero.

Top module: `pulser_ctrl`

## Requirements
- R1: After reset `lo_strobe` and `hi_strobe` are low, `amp_code` is 0, both outputs are disabled and the slow rate is in force.
- R2: A control write (`cmd_wr`=1, `cmd_sel`=0) takes `cmd_data` bit 0 as the low-output enable, bit 1 as the high-output enable and bit 2 as the rate choice (0 slow, 1 fast); bits 7..3 have no effect.
- R3: At the slow rate, strobes of an enabled output are exactly CLK_HZ/SLOW_HZ cycles apart (2,000,000 at the defaults).
- R4: At the fast rate, strobes of an enabled output are exactly CLK_HZ/FAST_HZ cycles apart (8,000 at the defaults).
- R5: Each strobe is high for one cycle. Both outputs take their timing from one shared counter, so when both are enabled their strobes fall in the same cycle.
- R6: The low and high outputs are enabled and disabled independently. A disabled output gives no strobes while the other output keeps pulsing.
- R7: A rate change takes effect at the next period boundary. The period already running ends at its old length, so no short or doubled pulse appears.
- R8: Clearing an enable suppresses that output from the first cycle after the write. The rate counter keeps running, so strobes that resume after re-enabling keep their original phase.
- R9: The amplitude register loads `cmd_data` on a write with `cmd_sel`=1, and the new value appears on `amp_code` in the following cycle. The register holds its value through control writes and through cycles without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Single-cycle command write strobe |
| cmd_sel | input | 1 | Register select: 0 control, 1 amplitude |
| cmd_data | input | 8 | Command data byte |
| lo_strobe | output | 1 | Low pulser clock strobe |
| hi_strobe | output | 1 | High pulser clock strobe |
| amp_code | output | 8 | Registered amplitude code for the DAC |

## Verification
A write sampled at an edge shows up on `amp_code` one cycle later. From the same edge it gates strobes that the next boundary would produce. A rate request waits for the boundary after the write, so gaps are measured only from the first strobe seen after that boundary. Such a gap equals the new period exactly. Across a mid-period rate change, the gap that spans the change must equal the old period. Inputs are driven and outputs sampled on the falling edge, and time is counted in whole cycles. This lets intervals and phase be compared with exact equality and a modulus.

// File: rtl/pulser_pkg.sv
package pulser_pkg;

    localparam int AMP_W    = 8;
    localparam int NUM_OUT  = 2;

    // control byte field positions
    localparam int CTL_LO_EN  = 0;
    localparam int CTL_HI_EN  = 1;
    localparam int CTL_FAST   = 2;

    // register select values
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_AMP  = 1'b1;

    // output channel indices
    localparam int CH_LO = 0;
    localparam int CH_HI = 1;

    typedef struct packed {
        logic [NUM_OUT-1:0] en;
        logic               fast_req;
        logic [AMP_W-1:0]   amp;
    } cmd_state_t;

endpackage

// File: rtl/pulser_cmd_regs.sv
module pulser_cmd_regs
    import pulser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               cmd_sel,
    input  logic [AMP_W-1:0]   cmd_data,
    output logic [NUM_OUT-1:0] en_d,
    output logic [NUM_OUT-1:0] en_q,
    output logic               fast_req_q,
    output logic [AMP_W-1:0]   amp_q
);

    cmd_state_t st_d;
    cmd_state_t st_q;

    logic ctrl_wr;
    logic amp_wr;

    always_comb begin
        ctrl_wr = cmd_wr && (cmd_sel == SEL_CTRL);
        amp_wr  = cmd_wr && (cmd_sel == SEL_AMP);
        st_d    = st_q;
        if (ctrl_wr) begin
            st_d.en[CH_LO] = cmd_data[CTL_LO_EN];
            st_d.en[CH_HI] = cmd_data[CTL_HI_EN];
            st_d.fast_req  = cmd_data[CTL_FAST];
        end
        if (amp_wr) begin
            st_d.amp = cmd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_d       = st_d.en;
    assign en_q       = st_q.en;
    assign fast_req_q = st_q.fast_req;
    assign amp_q      = st_q.amp;

    AST_AMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && cmd_sel == SEL_AMP) |=> $stable(amp_q)); // R9

    AST_AMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_sel == SEL_AMP) |=> (amp_q == $past(cmd_data))); // R9

endmodule

// File: rtl/pulser_rate_gen.sv
module pulser_rate_gen #(
    parameter int SLOW_CYC = 2_000_000,
    parameter int FAST_CYC = 8_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_req,
    output logic tick
);

    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CYC - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fast;
    } rate_state_t;

    rate_state_t rs_d;
    rate_state_t rs_q;

    logic [CW-1:0] last_q;
    logic          wrap;

    always_comb begin
        last_q = rs_q.fast ? FAST_LAST : SLOW_LAST;
        wrap   = (rs_q.cnt == last_q);
        rs_d   = rs_q;
        if (wrap) begin
            rs_d.cnt  = '0;
            rs_d.fast = fast_req;
        end else begin
            rs_d.cnt  = rs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign tick = wrap;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rs_q.cnt <= (rs_q.fast ? FAST_LAST : SLOW_LAST)); // R7

    AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rs_q.fast)); // R7

    AST_CNT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (rs_q.cnt == $past(rs_q.cnt) + 1'b1)); // R8

endmodule

// File: rtl/pulser_out_gate.sv
module pulser_out_gate
    import pulser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NUM_OUT-1:0] en_d,
    input  logic [NUM_OUT-1:0] en_q,
    output logic [NUM_OUT-1:0] strobe_q
);

    logic [NUM_OUT-1:0] strobe_d;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
        always_comb begin
            strobe_d[i] = tick && en_d[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                strobe_q[i] <= 1'b0;
            end else begin
                strobe_q[i] <= strobe_d[i];
            end
        end

        AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_q[i] |-> en_q[i]); // R8

        AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_q[i] |=> !strobe_q[i]); // R5
    end

    AST_SHARED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q[CH_LO] && en_q[CH_HI]) |-> strobe_q[CH_HI]); // R5

endmodule

// File: rtl/pulser_ctrl.sv
module pulser_ctrl
    import pulser_pkg::*;
#(
    parameter int CLK_HZ  = 16_000_000,
    parameter int SLOW_HZ = 8,
    parameter int FAST_HZ = 2_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             cmd_sel,
    input  logic [AMP_W-1:0] cmd_data,
    output logic             lo_strobe,
    output logic             hi_strobe,
    output logic [AMP_W-1:0] amp_code
);

    localparam int SLOW_CYC = CLK_HZ / SLOW_HZ;
    localparam int FAST_CYC = CLK_HZ / FAST_HZ;

    logic [NUM_OUT-1:0] en_d;
    logic [NUM_OUT-1:0] en_q;
    logic               fast_req_q;
    logic               tick;
    logic [NUM_OUT-1:0] strobe_q;

    pulser_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_sel    (cmd_sel),
        .cmd_data   (cmd_data),
        .en_d       (en_d),
        .en_q       (en_q),
        .fast_req_q (fast_req_q),
        .amp_q      (amp_code)
    );

    pulser_rate_gen #(
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_req (fast_req_q),
        .tick     (tick)
    );

    pulser_out_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en_d     (en_d),
        .en_q     (en_q),
        .strobe_q (strobe_q)
    );

    assign lo_strobe = strobe_q[CH_LO];
    assign hi_strobe = strobe_q[CH_HI];

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_strobe || hi_strobe) |-> $past(tick)); // R5

endmodule

// File: tb/pulser_ctrl_test.sv
module pulser_ctrl_test;

    localparam int CLK_HZ  = 16_000;
    localparam int SLOW_HZ = 8;
    localparam int FAST_HZ = 2_000;
    localparam int SLOW_P  = CLK_HZ / SLOW_HZ;   // 2000
    localparam int FAST_P  = CLK_HZ / FAST_HZ;   // 8
    localparam int LIMIT   = 3 * SLOW_P;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  amp;
        logic [31:0] gap;
        logic        lo;
        logic        hi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h01, 8'h10, SLOW_P, 1'b1, 1'b0},
        '{8'h03, 8'h80, SLOW_P, 1'b1, 1'b1},
        '{8'h06, 8'hFF, FAST_P, 1'b0, 1'b1},
        '{8'h05, 8'h01, FAST_P, 1'b1, 1'b0},
        '{8'h07, 8'h5A, FAST_P, 1'b1, 1'b1},
        '{8'h03, 8'h00, SLOW_P, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic       cmd_sel = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       lo_strobe;
    logic       hi_strobe;
    logic [7:0] amp_code;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulser_ctrl #(
        .CLK_HZ  (CLK_HZ),
        .SLOW_HZ (SLOW_HZ),
        .FAST_HZ (FAST_HZ)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_sel   (cmd_sel),
        .cmd_data  (cmd_data),
        .lo_strobe (lo_strobe),
        .hi_strobe (hi_strobe),
        .amp_code  (amp_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write(input logic sel, input logic [7:0] data);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_sel  = sel;
        cmd_data = data;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic wait_strobe(output int n, output bit lo, output bit hi);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(lo_strobe || hi_strobe) && n < LIMIT);
        lo = lo_strobe;
        hi = hi_strobe;
    endtask

    task automatic count_strobes(input int cycles, output int k);
        k = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (lo_strobe || hi_strobe) k++;
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n, k, t0, t1, t2;
        bit lo, hi;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(lo_strobe == 1'b0, "R1 lo_strobe", lo_strobe, 0);
        check(hi_strobe == 1'b0, "R1 hi_strobe", hi_strobe, 0);
        check(amp_code == 8'h00, "R1 amp_code", amp_code, 0);
        rst_n = 1'b1;
        count_strobes(SLOW_P + 100, k);
        check(k == 0, "R1 outputs off after reset", k, 0);

        // table walk: R2 R3 R4 R5 R6 R9
        foreach (VECS[i]) begin
            write(1'b0, VECS[i].ctrl);
            write(1'b1, VECS[i].amp);
            check(amp_code == VECS[i].amp, "R9 amp load", amp_code, VECS[i].amp);
            wait_strobe(n, lo, hi);
            wait_strobe(n, lo, hi);
            check(n == int'(VECS[i].gap), (VECS[i].gap == SLOW_P) ? "R3 slow gap" : "R4 fast gap",
                  n, VECS[i].gap);
            check(lo == VECS[i].lo, "R6 low output", lo, VECS[i].lo);
            check(hi == VECS[i].hi, "R5 high output", hi, VECS[i].hi);
            @(negedge clk);
            check(!lo_strobe && !hi_strobe, "R5 one-cycle strobe", lo_strobe | hi_strobe, 0);
        end

        // R8 immediate disable, counter keeps phase
        write(1'b0, 8'h05);
        wait_strobe(n, lo, hi);
        wait_strobe(n, lo, hi);
        t0 = cyc;
        repeat (3) @(negedge clk);
        write(1'b0, 8'h04);
        count_strobes(5 * FAST_P + 3, k);
        check(k == 0, "R8 disabled output quiet", k, 0);
        write(1'b0, 8'h05);
        wait_strobe(n, lo, hi);
        t1 = cyc;
        check(((t1 - t0) % FAST_P) == 0, "R8 phase kept", (t1 - t0) % FAST_P, 0);

        // R7 rate change mid-period
        write(1'b0, 8'h01);
        wait_strobe(n, lo, hi);
        wait_strobe(n, lo, hi);
        t0 = cyc;
        repeat (100) @(negedge clk);
        write(1'b0, 8'h05);
        wait_strobe(n, lo, hi);
        t1 = cyc;
        check(t1 - t0 == SLOW_P, "R7 old period completes", t1 - t0, SLOW_P);
        wait_strobe(n, lo, hi);
        t2 = cyc;
        check(t2 - t1 == FAST_P, "R7 new period after boundary", t2 - t1, FAST_P);

        // R2 upper bits ignored; R9 hold
        write(1'b1, 8'hC3);
        write(1'b0, 8'hF8);
        check(amp_code == 8'hC3, "R9 hold on control write", amp_code, 8'hC3);
        count_strobes(4 * FAST_P, k);
        check(k == 0, "R2 upper bits no enable", k, 0);
        @(negedge clk);
        cmd_sel  = 1'b1;
        cmd_data = 8'h33;
        repeat (5) @(negedge clk);
        check(amp_code == 8'hC3, "R9 hold without write", amp_code, 8'hC3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule